// File: doc/BRIEF.md
# Constant-Building Instruction Fusion Detector

This decode-stage block looks at a fetch group of four 32-bit instruction words each cycle and finds three-instruction sequences that build a full 64-bit constant into one register. The sequence is a lead instruction, which loads a sign-extended 20-bit value, followed by two step instructions. Each step shifts the register left by 22 and fills the freed low bits with a 22-bit value. Each such sequence leaves the block as a single fused micro-op that carries the destination register and the finished 64-bit constant. Every other valid instruction leaves unchanged as a single micro-op.

The block works on a six-position window. Positions 0 and 1 hold up to two words kept back from the previous group, and positions 2 to 5 hold fetch slots 0 to 3. Output lane p always corresponds to window position p, and results appear one clock after the group is presented. A sequence that begins in the last one or two slots of a group is held back and finished with the next group. If the next group does not complete it, the held words are released as plain micro-ops. A flush drops the held words together with the group presented in the same cycle.

Top module: `const_fuse_unit`

## Requirements
- R1: A lead word (bits [31:26] = 6'b011011, destination in [25:21], value in [19:0]) followed in the next two valid window positions by two step words (bits [31:27] = 5'b10110, destination in [26:22], value in [21:0]) is emitted as one micro-op with out_fused = 1, in the lane of the lead word. This holds at any slot offset.
- R2: A fused micro-op has out_dest equal to the common destination. Its out_imm equals ((sext64(v20) << 22 | a22) << 22) | b22, where a22 comes from the first step word and b22 from the second.
- R3: Output lane p reflects window position p one clock after the group is presented. Lanes 2 to 5 correspond to fetch slots 0 to 3, and lanes 0 and 1 carry words held over from the previous group.
- R4: The lanes of the second and third words of a fused sequence are invalid, so every instruction appears in at most one micro-op.
- R5: When candidate sequences overlap, the one starting at the oldest window position wins, and scanning resumes after its third word.
- R6: A destination mismatch, a wrong opcode or an invalid slot inside a candidate prevents fusion. Each valid word is then emitted singly with out_word equal to the original word, out_fused = 0, out_dest = 0 and out_imm = 0.
- R7: A lead word in slot 3, or a lead word in slot 2 followed by a matching step word in slot 3, is held back. Its lanes are invalid now, and it is completed in lanes 0 and 1 (a single held lead uses lane 1) if the next group supplies the rest of the sequence.
- R8: Held words that the next group does not complete are emitted as ordinary single micro-ops in lanes 0 and 1 (lane 1 alone for one word).
- R9: A flush makes every lane invalid on the following clock and discards any held words.
- R10: While rst_n is low, on a clock edge, all lanes become invalid and the held-word buffer is emptied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Drop held words and the current group |
| in_valid | input | 4 | Per-slot valid bits of the fetch group |
| in_word | input | 4x32 | Instruction words, element i is slot i |
| out_valid | output | 6 | Per-lane micro-op valid |
| out_fused | output | 6 | Lane carries a fused constant micro-op |
| out_word | output | 6x32 | Original word (the lead word for fused lanes) |
| out_dest | output | 6x5 | Destination register of a fused micro-op, else 0 |
| out_imm | output | 6x64 | Assembled 64-bit constant of a fused micro-op, else 0 |

## Verification
The bench places sequences at every slot offset. It also splits sequences after one and after two words across group boundaries, and checks that the finished constant lands in lane 0 or 1. A design that realigned wrongly would put the fused op in the wrong lane or leave a step word visible. Overlapping lead words, mismatched destinations, wrong opcodes and gaps from invalid slots are included. A matcher that was too loose would fuse these, and a matcher that was too strict would miss the real sequences. Held words are followed by groups that do not complete them, by a flush and by a reset. A wrong design would lose the words, fuse them anyway, or leak stale words into a later group.

// File: rtl/cfu_pkg.sv
// Package: shared widths and the constant assembly function for the
// constant-building fusion detector. Assumes 32-bit instruction words.
package cfu_pkg;
    localparam int WORD_W     = 32;
    localparam int RD_W       = 5;
    localparam int LEAD_IMM_W = 20;
    localparam int STEP_IMM_W = 22;
    localparam int CONST_W    = 64;
    localparam int LEAD_OP_W  = 6;
    localparam int STEP_OP_W  = 5;

    // Build the 64-bit constant from the three immediate pieces.
    function automatic logic [CONST_W-1:0] build_const(
        input logic [LEAD_IMM_W-1:0] hi,
        input logic [STEP_IMM_W-1:0] mid,
        input logic [STEP_IMM_W-1:0] lo
    );
        logic [CONST_W-1:0] acc;
        acc = {{(CONST_W-LEAD_IMM_W){hi[LEAD_IMM_W-1]}}, hi};
        acc = (acc << STEP_IMM_W) | CONST_W'(mid);
        acc = (acc << STEP_IMM_W) | CONST_W'(lo);
        return acc;
    endfunction
endpackage

// File: rtl/cfu_classify.sv
// Module: cfu_classify
// Decodes one instruction word into lead/step flags and destination fields.
// Assumes the opcode and destination positions given by parameters; the
// immediate fields sit at the bottom of the word.
module cfu_classify
    import cfu_pkg::*;
#(
    parameter logic [LEAD_OP_W-1:0] LEAD_OP     = 6'b011011,
    parameter int                   LEAD_OP_LSB = 26,
    parameter int                   LEAD_RD_LSB = 21,
    parameter logic [STEP_OP_W-1:0] STEP2_OP    = 5'b10110,
    parameter logic [STEP_OP_W-1:0] STEP3_OP    = 5'b10110,
    parameter int                   STEP_OP_LSB = 27,
    parameter int                   STEP_RD_LSB = 22
) (
    input  logic [WORD_W-1:0] word,
    output logic              is_lead,
    output logic              is_step2,
    output logic              is_step3,
    output logic [RD_W-1:0]   rd_lead,
    output logic [RD_W-1:0]   rd_step
);
    logic unused_word;

    // Opcode match and destination extraction for both instruction shapes.
    always_comb begin
        is_lead  = (word[LEAD_OP_LSB +: LEAD_OP_W] == LEAD_OP);
        is_step2 = (word[STEP_OP_LSB +: STEP_OP_W] == STEP2_OP);
        is_step3 = (word[STEP_OP_LSB +: STEP_OP_W] == STEP3_OP);
        rd_lead  = word[LEAD_RD_LSB +: RD_W];
        rd_step  = word[STEP_RD_LSB +: RD_W];
    end

    assign unused_word = ^word;
endmodule

// File: rtl/cfu_scan.sv
// Module: cfu_scan
// Scans the window oldest-first. It marks the positions that start a fused
// sequence, the positions swallowed by one, and the tail positions to hold
// for the next group. Assumes W >= 4 so that held positions are fetch slots.
module cfu_scan
    import cfu_pkg::*;
#(
    parameter int W = 6
) (
    input  logic [W-1:0]           valid,
    input  logic [W-1:0]           is_lead,
    input  logic [W-1:0]           is_step2,
    input  logic [W-1:0]           is_step3,
    input  logic [W-1:0][RD_W-1:0] rd_lead,
    input  logic [W-1:0][RD_W-1:0] rd_step,
    output logic [W-1:0]           start,
    output logic [W-1:0]           consumed,
    output logic [W-1:0]           held
);
    logic [W-1:0] pair_ok;
    logic [W-1:0] run_ok;
    logic         unused_edges;

    for (genvar p = 0; p < W; p++) begin : g_match
        if (p <= W - 2) begin : g_pair
            // Lead at p with a matching first step right behind it.
            assign pair_ok[p] = valid[p] & is_lead[p] & valid[p+1] & is_step2[p+1]
                              & (rd_lead[p] == rd_step[p+1]);
        end else begin : g_no_pair
            assign pair_ok[p] = 1'b0;
        end
        if (p <= W - 3) begin : g_run
            // Full three-word sequence starting at p.
            assign run_ok[p] = pair_ok[p] & valid[p+2] & is_step3[p+2]
                             & (rd_step[p+2] == rd_lead[p]);
        end else begin : g_no_run
            assign run_ok[p] = 1'b0;
        end
    end

    // Oldest-first walk: claim sequences, skip their tails, hold partial tails.
    always_comb begin
        int  eat;
        logic keep;
        start    = '0;
        consumed = '0;
        held     = '0;
        eat      = 0;
        keep     = 1'b0;
        for (int p = 0; p < W; p++) begin
            if (eat != 0) begin
                consumed[p] = 1'b1;
                eat         = eat - 1;
            end else if (keep) begin
                held[p] = 1'b1;
            end else if (run_ok[p]) begin
                start[p] = 1'b1;
                eat      = 2;
            end else if ((p == W - 2) && pair_ok[p]) begin
                held[p] = 1'b1;
                keep    = 1'b1;
            end else if ((p == W - 1) && valid[p] && is_lead[p]) begin
                held[p] = 1'b1;
            end
        end
    end

    assign unused_edges = ^{is_step2[0], is_step3[1:0], rd_step[0], rd_lead[W-1]};
endmodule

// File: rtl/cfu_carry.sv
// Module: cfu_carry
// Holds up to two leading words of a split sequence across a group boundary.
// Slot 0 of the buffer is the older word; a lone held lead sits in slot 1.
module cfu_carry
    import cfu_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic [1:0]          tail_held,
    input  logic [1:0][WORD_W-1:0] tail_word,
    output logic [1:0]          carry_valid,
    output logic [1:0][WORD_W-1:0] carry_word
);
    // Capture the held tail, or empty the buffer on reset or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            carry_valid <= '0;
            carry_word  <= '0;
        end else if (tail_held[0]) begin
            carry_valid <= 2'b11;
            carry_word  <= tail_word;
        end else if (tail_held[1]) begin
            carry_valid <= 2'b10;
            carry_word  <= {tail_word[1], {WORD_W{1'b0}}};
        end else begin
            carry_valid <= '0;
            carry_word  <= '0;
        end
    end
endmodule

// File: rtl/const_fuse_unit.sv
// Module: const_fuse_unit (top)
// Fuses lead + step + step constant-building sequences in a fetch group into
// single micro-ops. Window position p = output lane p: positions 0..1 are
// held-over words, positions 2..LANES+1 are fetch slots. One-cycle latency.
// Assumes LANES >= 2 and a new (possibly empty) group every cycle.
module const_fuse_unit
    import cfu_pkg::*;
#(
    parameter int                   LANES       = 4,
    parameter logic [LEAD_OP_W-1:0] LEAD_OP     = 6'b011011,
    parameter int                   LEAD_OP_LSB = 26,
    parameter int                   LEAD_RD_LSB = 21,
    parameter logic [STEP_OP_W-1:0] STEP2_OP    = 5'b10110,
    parameter logic [STEP_OP_W-1:0] STEP3_OP    = 5'b10110,
    parameter int                   STEP_OP_LSB = 27,
    parameter int                   STEP_RD_LSB = 22
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             flush,
    input  logic [LANES-1:0]                 in_valid,
    input  logic [LANES-1:0][WORD_W-1:0]     in_word,
    output logic [LANES+1:0]                 out_valid,
    output logic [LANES+1:0]                 out_fused,
    output logic [LANES+1:0][WORD_W-1:0]     out_word,
    output logic [LANES+1:0][RD_W-1:0]       out_dest,
    output logic [LANES+1:0][CONST_W-1:0]    out_imm
);
    localparam int W = LANES + 2;

    logic [1:0]                carry_valid;
    logic [1:0][WORD_W-1:0]    carry_word;
    logic [W-1:0]              win_valid;
    logic [W-1:0][WORD_W-1:0]  win_word;
    logic [W-1:0]              is_lead, is_step2, is_step3;
    logic [W-1:0][RD_W-1:0]    rd_lead, rd_step;
    logic [W-1:0]              start, consumed, held;

    // Window assembly: held words first, then the fetch slots in order.
    always_comb begin
        win_valid = {in_valid, carry_valid};
        win_word  = {in_word, carry_word};
    end

    for (genvar p = 0; p < W; p++) begin : g_cls
        cfu_classify #(
            .LEAD_OP(LEAD_OP), .LEAD_OP_LSB(LEAD_OP_LSB), .LEAD_RD_LSB(LEAD_RD_LSB),
            .STEP2_OP(STEP2_OP), .STEP3_OP(STEP3_OP),
            .STEP_OP_LSB(STEP_OP_LSB), .STEP_RD_LSB(STEP_RD_LSB)
        ) u_cls (
            .word     (win_word[p]),
            .is_lead  (is_lead[p]),
            .is_step2 (is_step2[p]),
            .is_step3 (is_step3[p]),
            .rd_lead  (rd_lead[p]),
            .rd_step  (rd_step[p])
        );
    end

    cfu_scan #(.W(W)) u_scan (
        .valid    (win_valid),
        .is_lead  (is_lead),
        .is_step2 (is_step2),
        .is_step3 (is_step3),
        .rd_lead  (rd_lead),
        .rd_step  (rd_step),
        .start    (start),
        .consumed (consumed),
        .held     (held)
    );

    cfu_carry u_carry (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush       (flush),
        .tail_held   (held[W-1:W-2]),
        .tail_word   (win_word[W-1:W-2]),
        .carry_valid (carry_valid),
        .carry_word  (carry_word)
    );

    for (genvar p = 0; p < W; p++) begin : g_emit
        logic [CONST_W-1:0] lane_const;
        if (p <= W - 3) begin : g_const
            assign lane_const = build_const(win_word[p][LEAD_IMM_W-1:0],
                                            win_word[p+1][STEP_IMM_W-1:0],
                                            win_word[p+2][STEP_IMM_W-1:0]);
        end else begin : g_no_const
            assign lane_const = '0;
        end

        // Register one output lane: single, fused, or empty.
        always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
                out_valid[p] <= 1'b0;
                out_fused[p] <= 1'b0;
                out_word[p]  <= '0;
                out_dest[p]  <= '0;
                out_imm[p]   <= '0;
            end else begin
                out_valid[p] <= win_valid[p] & ~consumed[p] & ~held[p];
                out_fused[p] <= start[p];
                out_word[p]  <= win_word[p];
                out_dest[p]  <= start[p] ? rd_lead[p] : '0;
                out_imm[p]   <= start[p] ? lane_const : '0;
            end
        end
    end
endmodule

// File: rtl/const_fuse_chk.sv
// Module: const_fuse_chk
// Checker bound to const_fuse_unit; watches its ports only.
module const_fuse_chk
    import cfu_pkg::*;
#(
    parameter int                   LANES       = 4,
    parameter logic [LEAD_OP_W-1:0] LEAD_OP     = 6'b011011,
    parameter int                   LEAD_OP_LSB = 26,
    parameter int                   LEAD_RD_LSB = 21
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          flush,
    input logic [LANES-1:0]              in_valid,
    input logic [LANES-1:0][WORD_W-1:0]  in_word,
    input logic [LANES+1:0]              out_valid,
    input logic [LANES+1:0]              out_fused,
    input logic [LANES+1:0][WORD_W-1:0]  out_word,
    input logic [LANES+1:0][RD_W-1:0]    out_dest,
    input logic [LANES+1:0][CONST_W-1:0] out_imm
);
    localparam int W = LANES + 2;
    logic unused_chk;
    assign unused_chk = ^{in_valid, in_word, out_word};

    // R10: reset empties every lane on the next clock.
    assert_reset_clears_R10: assert property (@(posedge clk)
        !rst_n |=> (out_valid == '0));

    // R9: flush empties every lane on the next clock.
    assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (out_valid == '0));

    // R7: a lead word in the last slot is always held, never emitted at once.
    assert_tail_lead_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && in_valid[LANES-1]
         && in_word[LANES-1][LEAD_OP_LSB +: LEAD_OP_W] == LEAD_OP)
        |=> !out_valid[W-1]);

    // R1: no sequence can start in the last two window positions.
    assert_no_tail_fuse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !out_fused[W-1] && !out_fused[W-2]);

    for (genvar i = 0; i < W; i++) begin : g_lane
        // R2: fused lane carries the lead word, its destination and top bits.
        assert_fused_fields_R2: assert property (@(posedge clk) disable iff (!rst_n)
            out_fused[i] |-> (out_valid[i]
                && out_word[i][LEAD_OP_LSB +: LEAD_OP_W] == LEAD_OP
                && out_dest[i] == out_word[i][LEAD_RD_LSB +: RD_W]
                && out_imm[i][CONST_W-1 -: LEAD_IMM_W] == out_word[i][LEAD_IMM_W-1:0]));

        // R6: a single micro-op carries no constant and no destination.
        assert_single_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[i] && !out_fused[i]) |-> (out_imm[i] == '0 && out_dest[i] == '0));

        if (i <= W - 3) begin : g_swallow
            // R4: the two words behind a fused lead are not emitted again.
            assert_swallowed_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
                out_fused[i] |-> (!out_valid[i+1] && !out_valid[i+2]));
        end
    end
endmodule

bind const_fuse_unit const_fuse_chk #(
    .LANES(LANES), .LEAD_OP(LEAD_OP), .LEAD_OP_LSB(LEAD_OP_LSB), .LEAD_RD_LSB(LEAD_RD_LSB)
) u_chk (.*);

// File: tb/const_fuse_unit_tb.sv
`timescale 1ns/1ps
module const_fuse_unit_tb;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               flush = 1'b0;
    logic [3:0]         in_valid = '0;
    logic [3:0][31:0]   in_word = '0;
    logic [5:0]         out_valid, out_fused;
    logic [5:0][31:0]   out_word;
    logic [5:0][4:0]    out_dest;
    logic [5:0][63:0]   out_imm;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    const_fuse_unit u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid), .in_word(in_word),
        .out_valid(out_valid), .out_fused(out_fused), .out_word(out_word),
        .out_dest(out_dest), .out_imm(out_imm)
    );

    // Word builders following the encodings stated in R1.
    function automatic logic [31:0] ld(input int rd, input logic [19:0] v);
        return {6'b011011, 5'(rd), 1'b0, v};
    endfunction
    function automatic logic [31:0] st(input int rd, input logic [21:0] v);
        return {5'b10110, 5'(rd), v};
    endfunction
    function automatic logic [31:0] ot(input int x);
        return {6'b000001, 26'(x)};
    endfunction
    // Expected constant per the R2 formula.
    function automatic logic [63:0] kc(input logic [19:0] h, input logic [21:0] a,
                                       input logic [21:0] b);
        logic [63:0] s;
        s = {{44{h[19]}}, h};
        return (((s << 22) | 64'(a)) << 22) | 64'(b);
    endfunction

    typedef struct packed {
        logic [3:0]       v;
        logic [3:0][31:0] w;   // {slot3, slot2, slot1, slot0}
        logic             fl;
        logic [5:0]       ev;
        logic [5:0]       ef;
        logic [4:0]       ed;
        logic [63:0]      ei;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t TBL [NV] = '{
        // R1 offset slot 0
        '{4'b1111, {ot(1), st(3,22'h155555), st(3,22'h2ABCDE), ld(3,20'h12345)}, 1'b0,
          6'b100100, 6'b000100, 5'd3, kc(20'h12345,22'h2ABCDE,22'h155555)},
        // R1 offset slot 1
        '{4'b1111, {st(3,22'h33333), st(3,22'h22222), ld(3,20'h11111), ot(2)}, 1'b0,
          6'b001100, 6'b001000, 5'd3, kc(20'h11111,22'h22222,22'h33333)},
        // R7 hold two words
        '{4'b1111, {st(3,22'h000001), ld(3,20'hFEDCB), ot(3), ot(4)}, 1'b0,
          6'b001100, 6'b000000, 5'd0, 64'd0},
        // R7 completion at lane 0, R2 negative lead value
        '{4'b1111, {ot(7), ot(6), ot(5), st(3,22'h3FFFFF)}, 1'b0,
          6'b111001, 6'b000001, 5'd3, kc(20'hFEDCB,22'h000001,22'h3FFFFF)},
        // R7 hold one word
        '{4'b1111, {ld(5,20'h00001), ot(10), ot(9), ot(8)}, 1'b0,
          6'b011100, 6'b000000, 5'd0, 64'd0},
        // R7 completion at lane 1
        '{4'b1111, {ot(12), ot(11), st(5,22'h000100), st(5,22'h000010)}, 1'b0,
          6'b110010, 6'b000010, 5'd5, kc(20'h00001,22'h000010,22'h000100)},
        // R7 hold one word
        '{4'b1111, {ld(6,20'h00ABC), ot(15), ot(14), ot(13)}, 1'b0,
          6'b011100, 6'b000000, 5'd0, 64'd0},
        // R8 empty group releases held word
        '{4'b0000, {ot(0), ot(0), ot(0), ot(0)}, 1'b0,
          6'b000010, 6'b000000, 5'd0, 64'd0},
        // R6 destination mismatch
        '{4'b1111, {ot(16), st(4,22'h5), st(3,22'h4), ld(3,20'h3)}, 1'b0,
          6'b111100, 6'b000000, 5'd0, 64'd0},
        // R5 overlapping leads, oldest valid start wins
        '{4'b1111, {st(3,22'h2), st(3,22'h1), ld(3,20'h55555), ld(3,20'hAAAAA)}, 1'b0,
          6'b001100, 6'b001000, 5'd3, kc(20'h55555,22'h1,22'h2)},
        // R6 invalid slot breaks sequence
        '{4'b1011, {st(3,22'h9), st(3,22'h8), st(3,22'h7), ld(3,20'h6)}, 1'b0,
          6'b101100, 6'b000000, 5'd0, 64'd0},
        // R1/R7 fuse plus hold in one group
        '{4'b1111, {ld(2,20'h7), st(3,22'h4), st(3,22'h3), ld(3,20'h00FFF)}, 1'b0,
          6'b000100, 6'b000100, 5'd3, kc(20'h00FFF,22'h3,22'h4)},
        // R9 flush
        '{4'b1111, {ot(20), ot(19), ot(18), ot(17)}, 1'b1,
          6'b000000, 6'b000000, 5'd0, 64'd0},
        // R9 held word gone after flush
        '{4'b1111, {ot(22), ot(21), st(2,22'h1), st(2,22'h1)}, 1'b0,
          6'b111100, 6'b000000, 5'd0, 64'd0},
        // R7 hold two words
        '{4'b1111, {st(7,22'h1), ld(7,20'h2), ot(24), ot(23)}, 1'b0,
          6'b001100, 6'b000000, 5'd0, 64'd0},
        // R8 gap in next group releases both
        '{4'b1110, {ot(27), ot(26), ot(25), st(7,22'h3)}, 1'b0,
          6'b111011, 6'b000000, 5'd0, 64'd0},
        // R7 hold two words
        '{4'b1111, {st(8,22'h1), ld(8,20'h2), ot(29), ot(28)}, 1'b0,
          6'b001100, 6'b000000, 5'd0, 64'd0},
        // R8/R5 next group starts a fresh sequence
        '{4'b1111, {ot(30), st(9,22'h9), st(9,22'h9), ld(9,20'h9)}, 1'b0,
          6'b100111, 6'b000100, 5'd9, kc(20'h9,22'h9,22'h9)},
        // R7 hold one word
        '{4'b1111, {ld(3,20'h1), ot(33), ot(32), ot(31)}, 1'b0,
          6'b011100, 6'b000000, 5'd0, 64'd0},
        // R6/R8 mismatched destination across boundary
        '{4'b1111, {ot(35), ot(34), st(3,22'h1), st(4,22'h1)}, 1'b0,
          6'b111110, 6'b000000, 5'd0, 64'd0},
        // R6 wrong opcode in third position
        '{4'b1111, {ot(37), ot(36), st(1,22'h1), ld(1,20'h1)}, 1'b0,
          6'b111100, 6'b000000, 5'd0, 64'd0}
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic [3:0] v, input logic [3:0][31:0] w, input logic f);
        in_valid = v;
        in_word  = w;
        flush    = f;
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R10 reset state with a fusable group present
        drive(4'b1111, {ot(1), st(3,22'h1), st(3,22'h1), ld(3,20'h1)}, 1'b0);
        step();
        step();
        check(out_valid == 6'b0, "R10 reset valid", 64'(out_valid), 64'd0);
        check(out_fused == 6'b0, "R10 reset fused", 64'(out_fused), 64'd0);
        rst_n = 1'b1;
        drive(4'b0000, '0, 1'b0);
        step();

        // Table walk
        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].v, TBL[i].w, TBL[i].fl);
            step();
            check(out_valid == TBL[i].ev, $sformatf("R4/R3 lane valid vec %0d", i),
                  64'(out_valid), 64'(TBL[i].ev));
            check(out_fused == TBL[i].ef, $sformatf("R1 fused mask vec %0d", i),
                  64'(out_fused), 64'(TBL[i].ef));
            for (int l = 0; l < 6; l++) begin
                if (TBL[i].ef[l]) begin
                    check(out_imm[l] == TBL[i].ei, $sformatf("R2 constant vec %0d", i),
                          out_imm[l], TBL[i].ei);
                    check(out_dest[l] == TBL[i].ed, $sformatf("R2 dest vec %0d", i),
                          64'(out_dest[l]), 64'(TBL[i].ed));
                end
            end
        end

        // R8 released word is the original lead word
        drive(4'b1111, {ld(6,20'h00ABC), ot(42), ot(41), ot(40)}, 1'b0);
        step();
        check(out_valid == 6'b011100, "R7 hold lane mask", 64'(out_valid), 64'h1C);
        drive(4'b0000, '0, 1'b0);
        step();
        check(out_valid == 6'b000010, "R8 release mask", 64'(out_valid), 64'h02);
        check(out_word[1] == ld(6,20'h00ABC), "R8 released word", 64'(out_word[1]),
              64'(ld(6,20'h00ABC)));
        check(out_fused[1] == 1'b0, "R8 released unfused", 64'(out_fused[1]), 64'd0);

        // R6 single pass-through of an unmatched lead
        drive(4'b1111, {ot(12), st(2,22'h5), ld(2,20'h4), ot(11)}, 1'b0);
        step();
        check(out_fused == 6'b0, "R6 no fuse", 64'(out_fused), 64'd0);
        check(out_word[3] == ld(2,20'h4), "R6 word kept", 64'(out_word[3]),
              64'(ld(2,20'h4)));
        check(out_imm[3] == 64'd0 && out_dest[3] == 5'd0, "R6 clean fields",
              out_imm[3], 64'd0);
        check(out_word[2] == ot(11), "R3 slot0 in lane2", 64'(out_word[2]), 64'(ot(11)));

        // R10 reset drops a held word
        drive(4'b1111, {ld(4,20'h3), ot(45), ot(44), ot(43)}, 1'b0);
        step();
        rst_n = 1'b0;
        drive(4'b1111, {ot(47), ot(46), st(4,22'h1), st(4,22'h1)}, 1'b0);
        step();
        check(out_valid == 6'b0, "R10 reset mid-run", 64'(out_valid), 64'd0);
        rst_n = 1'b1;
        step();
        check(out_valid == 6'b111100, "R10 held word dropped", 64'(out_valid), 64'h3C);
        check(out_fused == 6'b0, "R10 no late fuse", 64'(out_fused), 64'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule